// File: doc/BRIEF.md
# I2C master command sequencer

This block is an I2C bus master that a host steers one operation at a time. The host pulses one of five command inputs: start, repeated start, stop, receive, acknowledge. Writing the data buffer sends a byte. Each operation runs to completion on its own. While it runs, its bit in `cmd_active` is high, and that bit drops when the operation ends. Completion raises a sticky interrupt flag. The host then issues the next step of the transfer, so the bus moves only as fast as the host reacts.

The block drives the open-drain SCL and SDA lines through pull-low enables and reads the real line levels back. Each SCL period is four quarter phases, and each quarter lasts `reload + 1` system clocks. A transmitted byte goes out MSB first, and the slave's answer on the ninth clock is kept as an acknowledge status. A received byte is shifted in MSB first and lands in the same data buffer that the host reads. A bus monitor watches the lines for START and STOP conditions, so the block knows when the bus is taken. Nothing is queued. A buffer write or a command that arrives while an operation is running is rejected, and a rejected write is reported as a collision.

Top module: `i2c_cmd_master`

## Requirements
- R1: Every quarter of an SCL period lasts `reload + 1` clocks. Start, repeated start, stop and acknowledge take 4 quarters each. A byte transmission takes 36 quarters and a reception takes 32. `irq` is set N*(reload+1) clocks after the edge that accepted the operation, where N is its quarter count.
- R2: `cmd_start` raises `cmd_active[0]`. It then pulls SDA low while SCL is released, then pulls SCL low. When the START is done, `cmd_active[0]` clears and `irq` is set.
- R3: Repeated start (`cmd_active[1]`), stop (`cmd_active[2]`), receive (`cmd_active[3]`) and acknowledge (`cmd_active[4]`) each clear their bit on completion, and each completion sets `irq`.
- R4: A buffer write sends the 8 bits MSB first, with SDA changing only while SCL is low. On the ninth clock the block releases SDA and stores the level it samples in `ack_stat` (0 = ACK, 1 = NACK).
- R5: `buf_full` is 1 from the accepted buffer write until the transmission completes, and 0 after.
- R6: A buffer write while any operation is running sets `wcol`, and leaves `rd_data` and the running transfer unchanged.
- R7: A receive shifts 8 bits in MSB first, puts the byte in `rd_data`, and sets `buf_full` and `irq`. A pulse on `rd_en` clears `buf_full`.
- R8: A reception that completes while `buf_full` is 1 sets `rx_ovf`, and the buffer keeps the byte it already held.
- R9: The acknowledge operation drives `ack_data` on SDA during one extra SCL pulse: 0 pulls SDA low, 1 releases it.
- R10: An SDA fall while SCL is high sets `start_seen` and clears `stop_seen`. An SDA rise while SCL is high does the opposite. `start_seen` = 1 means the bus is busy.
- R11: `cmd_start` while `start_seen` is 1 and the block is idle sets `bus_col` and starts nothing.
- R12: `irq`, `wcol`, `rx_ovf` and `bus_col` stay set until the host writes a 1 to their `clr_flags` bit: bit 0 `irq`, bit 1 `wcol`, bit 2 `rx_ovf`, bit 3 `bus_col`. Other bits are left alone.
- R13: Commands issued while an operation runs are ignored, and at most one `cmd_active` bit is ever set.
- R14: After reset both lines are released, all flags are 0 and `cmd_active` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reload | input | DIV_W | Quarter-phase divider reload value |
| cmd_start | input | 1 | Request a START condition |
| cmd_rstart | input | 1 | Request a repeated START |
| cmd_stop | input | 1 | Request a STOP condition |
| cmd_rcv | input | 1 | Request reception of one byte |
| cmd_ack | input | 1 | Request an acknowledge pulse |
| ack_data | input | 1 | Level to send on the acknowledge pulse |
| wr_en | input | 1 | Buffer write strobe, launches a transmission |
| wr_data | input | DATA_W | Byte to write to the buffer |
| rd_en | input | 1 | Host read of the buffer, clears buffer-full |
| clr_flags | input | 4 | Write-one-to-clear for irq, wcol, rx_ovf, bus_col |
| scl_in | input | 1 | Sensed SCL line level |
| sda_in | input | 1 | Sensed SDA line level |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| rd_data | output | DATA_W | Data buffer contents |
| cmd_active | output | 5 | Running command: start, rstart, stop, rcv, ack (bit 0 up) |
| buf_full | output | 1 | Buffer-full status |
| ack_stat | output | 1 | Last acknowledge from the slave |
| irq | output | 1 | Operation-complete flag |
| wcol | output | 1 | Write-collision flag |
| rx_ovf | output | 1 | Receive-overflow flag |
| bus_col | output | 1 | START requested on a busy bus |
| start_seen | output | 1 | START observed on the bus, bus busy |
| stop_seen | output | 1 | STOP observed on the bus |

## Verification
The assertions check several rules on every cycle. SDA must hold still while SCL is high during data and acknowledge bits. Buffer-full must be high for a whole transmission. A rejected write must leave the buffer alone. At most one command may run at a time. Every completion must raise the interrupt. Overflow and bus collision must appear on the cycle after their cause. Only the bench scenarios can show the rest. These are the SCL timing for each reload value and the MSB-first bit order seen by a slave. They also cover the ACK and NACK results, the bytes received, the acknowledge level on the wire, and that the START/STOP monitor follows what the block itself puts on the bus.

// File: rtl/i2cq_pkg.sv
package i2cq_pkg;

    typedef enum logic [2:0] {
        OP_IDLE,
        OP_START,
        OP_RSTART,
        OP_STOP,
        OP_TX,
        OP_RX,
        OP_ACK
    } op_e;

    // pull-low requests for the two open-drain lines
    typedef struct packed {
        logic scl_low;
        logic sda_low;
    } drive_t;

    localparam int FLAG_IRQ  = 0;
    localparam int FLAG_WCOL = 1;
    localparam int FLAG_OVF  = 2;
    localparam int FLAG_BCOL = 3;
    localparam int FLAG_W    = 4;
    localparam int CMD_W     = 5;

    // Line levels for quarter q of the current operation.
    function automatic drive_t line_drive(op_e op, logic [1:0] q, logic bit_val);
        drive_t d;
        d.scl_low = 1'b0;
        d.sda_low = 1'b0;
        case (op)
            OP_START: begin
                d.scl_low = (q == 2'd3);
                d.sda_low = q[1];
            end
            OP_RSTART: begin
                d.scl_low = (q == 2'd0) || (q == 2'd3);
                d.sda_low = q[1];
            end
            OP_STOP: begin
                d.scl_low = (q == 2'd0);
                d.sda_low = !q[1];
            end
            OP_TX, OP_RX, OP_ACK: begin
                d.scl_low = (q == 2'd0) || (q == 2'd3);
                d.sda_low = !bit_val;
            end
            default: ;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/i2cq_qtick.sv
module i2cq_qtick #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic             run,
    input  logic [DIV_W-1:0] reload,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (restart || (run && cnt == '0)) begin
            cnt <= reload;
        end else if (run) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign tick = run && !restart && (cnt == '0);
endmodule

// File: rtl/i2cq_busmon.sv
module i2cq_busmon (
    input  logic clk,
    input  logic rst,
    input  logic scl_in,
    input  logic sda_in,
    output logic start_seen,
    output logic stop_seen
);
    logic scl_q, sda_q;
    logic st_det, sp_det;

    assign st_det = scl_q && scl_in && sda_q && !sda_in;
    assign sp_det = scl_q && scl_in && !sda_q && sda_in;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q      <= 1'b1;
            sda_q      <= 1'b1;
            start_seen <= 1'b0;
            stop_seen  <= 1'b0;
        end else begin
            scl_q <= scl_in;
            sda_q <= sda_in;
            if (st_det) begin
                start_seen <= 1'b1;
                stop_seen  <= 1'b0;
            end else if (sp_det) begin
                start_seen <= 1'b0;
                stop_seen  <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/i2cq_engine.sv
module i2cq_engine
    import i2cq_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              launch,
    input  op_e               launch_op,
    input  logic [DATA_W-1:0] tx_byte,
    input  logic              ack_bit,
    input  logic              tick,
    input  logic              sda_in,
    output op_e               op,
    output logic              done,
    output logic [DATA_W-1:0] rx_byte,
    output logic              ack_valid,
    output logic              ack_val,
    output logic              scl_oe,
    output logic              sda_oe
);
    localparam int SH_W  = DATA_W + 1;
    localparam int CNT_W = $clog2(SH_W + 1);

    logic [1:0]       q;
    logic [CNT_W-1:0] bitn, last_bit;
    logic [SH_W-1:0]  sh;
    logic             scl_hold, sda_hold;
    logic             sample, bit_end;
    drive_t           drv;

    assign sample    = tick && (q == 2'd1);
    assign bit_end   = tick && (q == 2'd3);
    assign done      = bit_end && (bitn == last_bit);
    assign ack_valid = sample && (op == OP_TX) && (bitn == last_bit);
    assign ack_val   = sda_in;

    always_comb begin
        drv = line_drive(op, q, sh[SH_W-1]);
        if (op == OP_IDLE) begin
            scl_oe = scl_hold;
            sda_oe = sda_hold;
        end else begin
            scl_oe = drv.scl_low;
            sda_oe = drv.sda_low;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            op       <= OP_IDLE;
            q        <= 2'd0;
            bitn     <= '0;
            last_bit <= '0;
            sh       <= '1;
            rx_byte  <= '0;
            scl_hold <= 1'b0;
            sda_hold <= 1'b0;
        end else if (launch) begin
            op   <= launch_op;
            q    <= 2'd0;
            bitn <= '0;
            case (launch_op)
                OP_TX: begin
                    sh       <= {tx_byte, 1'b1};
                    last_bit <= CNT_W'(DATA_W);
                end
                OP_RX: begin
                    sh       <= '1;
                    last_bit <= CNT_W'(DATA_W - 1);
                end
                OP_ACK: begin
                    sh       <= {ack_bit, {DATA_W{1'b1}}};
                    last_bit <= '0;
                end
                default: begin
                    sh       <= '1;
                    last_bit <= '0;
                end
            endcase
        end else if (tick) begin
            q <= q + 2'd1;
            if (sample && op == OP_RX) begin
                rx_byte <= {rx_byte[DATA_W-2:0], sda_in};
            end
            if (bit_end) begin
                if (done) begin
                    op       <= OP_IDLE;
                    scl_hold <= drv.scl_low;
                    sda_hold <= drv.sda_low;
                end else begin
                    bitn <= bitn + 1'b1;
                    sh   <= {sh[SH_W-2:0], 1'b1};
                end
            end
        end
    end
endmodule

// File: rtl/i2c_cmd_master.sv
module i2c_cmd_master
    import i2cq_pkg::*;
#(
    parameter int DIV_W  = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DIV_W-1:0]  reload,
    input  logic              cmd_start,
    input  logic              cmd_rstart,
    input  logic              cmd_stop,
    input  logic              cmd_rcv,
    input  logic              cmd_ack,
    input  logic              ack_data,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [3:0]        clr_flags,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              scl_oe,
    output logic              sda_oe,
    output logic [DATA_W-1:0] rd_data,
    output logic [4:0]        cmd_active,
    output logic              buf_full,
    output logic              ack_stat,
    output logic              irq,
    output logic              wcol,
    output logic              rx_ovf,
    output logic              bus_col,
    output logic              start_seen,
    output logic              stop_seen
);
    op_e               eng_op, sel_op;
    logic              idle, launch, start_blocked, wr_taken, wr_col;
    logic              tick, eng_done, ack_valid, ack_val;
    logic [DATA_W-1:0] rx_byte, dbuf_q;
    logic              rx_done, tx_done;

    assign idle = (eng_op == OP_IDLE);

    // fixed priority among simultaneous requests
    always_comb begin
        sel_op = OP_IDLE;
        if (cmd_start)       sel_op = OP_START;
        else if (cmd_rstart) sel_op = OP_RSTART;
        else if (cmd_stop)   sel_op = OP_STOP;
        else if (cmd_rcv)    sel_op = OP_RX;
        else if (cmd_ack)    sel_op = OP_ACK;
        else if (wr_en)      sel_op = OP_TX;
    end

    assign start_blocked = idle && cmd_start && start_seen;
    assign launch        = idle && (sel_op != OP_IDLE) && !start_blocked;
    assign wr_taken      = launch && (sel_op == OP_TX);
    assign wr_col        = wr_en && !wr_taken;
    assign rx_done       = eng_done && (eng_op == OP_RX);
    assign tx_done       = eng_done && (eng_op == OP_TX);

    i2cq_qtick #(.DIV_W(DIV_W)) u_qtick (
        .clk     (clk),
        .rst     (rst),
        .restart (launch),
        .run     (!idle),
        .reload  (reload),
        .tick    (tick)
    );

    i2cq_engine #(.DATA_W(DATA_W)) u_engine (
        .clk       (clk),
        .rst       (rst),
        .launch    (launch),
        .launch_op (sel_op),
        .tx_byte   (wr_data),
        .ack_bit   (ack_data),
        .tick      (tick),
        .sda_in    (sda_in),
        .op        (eng_op),
        .done      (eng_done),
        .rx_byte   (rx_byte),
        .ack_valid (ack_valid),
        .ack_val   (ack_val),
        .scl_oe    (scl_oe),
        .sda_oe    (sda_oe)
    );

    i2cq_busmon u_busmon (
        .clk        (clk),
        .rst        (rst),
        .scl_in     (scl_in),
        .sda_in     (sda_in),
        .start_seen (start_seen),
        .stop_seen  (stop_seen)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            dbuf_q   <= '0;
            buf_full <= 1'b0;
            ack_stat <= 1'b0;
            irq      <= 1'b0;
            wcol     <= 1'b0;
            rx_ovf   <= 1'b0;
            bus_col  <= 1'b0;
        end else begin
            if (wr_taken)                dbuf_q <= wr_data;
            else if (rx_done && !buf_full) dbuf_q <= rx_byte;

            if (wr_taken)                          buf_full <= 1'b1;
            else if (tx_done)                      buf_full <= 1'b0;
            else if (rx_done)                      buf_full <= 1'b1;
            else if (rd_en && eng_op != OP_TX)     buf_full <= 1'b0;

            if (ack_valid) ack_stat <= ack_val;

            if (eng_done)                  irq <= 1'b1;
            else if (clr_flags[FLAG_IRQ])  irq <= 1'b0;

            if (wr_col)                    wcol <= 1'b1;
            else if (clr_flags[FLAG_WCOL]) wcol <= 1'b0;

            if (rx_done && buf_full)       rx_ovf <= 1'b1;
            else if (clr_flags[FLAG_OVF])  rx_ovf <= 1'b0;

            if (start_blocked)             bus_col <= 1'b1;
            else if (clr_flags[FLAG_BCOL]) bus_col <= 1'b0;
        end
    end

    assign rd_data    = dbuf_q;
    assign cmd_active = {eng_op == OP_ACK, eng_op == OP_RX, eng_op == OP_STOP,
                         eng_op == OP_RSTART, eng_op == OP_START};
endmodule

// File: rtl/i2cq_chk.sv
module i2cq_chk
    import i2cq_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input op_e               op,
    input logic              eng_done,
    input logic              scl_oe,
    input logic              sda_oe,
    input logic              buf_full,
    input logic              wr_en,
    input logic [DATA_W-1:0] dbuf_q,
    input logic              wcol,
    input logic [4:0]        cmd_active,
    input logic              cmd_start,
    input logic              start_seen,
    input logic              bus_col,
    input logic              rx_ovf,
    input logic              irq
);
    logic bit_op;
    assign bit_op = (op == OP_TX) || (op == OP_RX) || (op == OP_ACK);

    p_sda_still_scl_high_r4: assert property (@(posedge clk) disable iff (rst)
        (bit_op && !scl_oe && !$past(scl_oe)) |-> $stable(sda_oe));

    p_full_during_tx_r5: assert property (@(posedge clk) disable iff (rst)
        (op == OP_TX) |-> buf_full);

    p_wcol_keeps_buf_r6: assert property (@(posedge clk) disable iff (rst)
        (wr_en && op == OP_TX) |=> (wcol && dbuf_q == $past(dbuf_q)));

    p_one_active_r13: assert property (@(posedge clk) disable iff (rst)
        $onehot0(cmd_active));

    p_busy_start_r11: assert property (@(posedge clk) disable iff (rst)
        (cmd_start && start_seen && op == OP_IDLE) |=> (bus_col && cmd_active == 5'b0));

    p_no_overflow_r8: assert property (@(posedge clk) disable iff (rst)
        (eng_done && op == OP_RX && buf_full) |=> rx_ovf);

    p_done_irq_r3: assert property (@(posedge clk) disable iff (rst)
        eng_done |=> irq);

    p_start_selfclear_r2: assert property (@(posedge clk) disable iff (rst)
        (eng_done && op == OP_START) |=> !cmd_active[0]);
endmodule

bind i2c_cmd_master i2cq_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .op         (eng_op),
    .eng_done   (eng_done),
    .scl_oe     (scl_oe),
    .sda_oe     (sda_oe),
    .buf_full   (buf_full),
    .wr_en      (wr_en),
    .dbuf_q     (dbuf_q),
    .wcol       (wcol),
    .cmd_active (cmd_active),
    .cmd_start  (cmd_start),
    .start_seen (start_seen),
    .bus_col    (bus_col),
    .rx_ovf     (rx_ovf),
    .irq        (irq)
);

// File: tb/i2c_cmd_master_tb_top.sv
`timescale 1ns/1ps
module i2c_cmd_master_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] reload_r = 8'd2;
    logic       cmd_start = 0, cmd_rstart = 0, cmd_stop = 0, cmd_rcv = 0, cmd_ack = 0;
    logic       ack_data = 0, wr_en = 0, rd_en = 0;
    logic [7:0] wr_data = 8'h00;
    logic [3:0] drv_clr = 4'h0;
    logic       mon_clr = 1'b0;
    logic [3:0] clr_flags;
    logic       slv_low = 1'b0;
    logic       scl_line, sda_line;
    logic       scl_oe, sda_oe, buf_full, ack_stat, irq, wcol, rx_ovf, bus_col;
    logic       start_seen, stop_seen;
    logic [7:0] rd_data;
    logic [4:0] cmd_active;

    always #4 clk = ~clk;

    assign clr_flags = drv_clr | {3'b000, mon_clr};
    assign scl_line  = ~scl_oe;
    assign sda_line  = ~(sda_oe | slv_low);

    i2c_cmd_master dut_i (
        .clk(clk), .rst(rst), .reload(reload_r),
        .cmd_start(cmd_start), .cmd_rstart(cmd_rstart), .cmd_stop(cmd_stop),
        .cmd_rcv(cmd_rcv), .cmd_ack(cmd_ack), .ack_data(ack_data),
        .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .clr_flags(clr_flags),
        .scl_in(scl_line), .sda_in(sda_line), .scl_oe(scl_oe), .sda_oe(sda_oe),
        .rd_data(rd_data), .cmd_active(cmd_active), .buf_full(buf_full),
        .ack_stat(ack_stat), .irq(irq), .wcol(wcol), .rx_ovf(rx_ovf),
        .bus_col(bus_col), .start_seen(start_seen), .stop_seen(stop_seen)
    );

    typedef struct packed {
        int         lat;
        logic       chk_ack;
        logic       ack;
        logic       chk_dat;
        logic [7:0] dat;
    } exp_t;

    exp_t  sb_q[$];
    string sb_rq[$];
    int    cyc = 0;
    int    launch_cyc = 0;
    int    n_chk = 0;
    int    n_bad = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string rq, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    function automatic int qlen(input int quarters);
        return quarters * (int'(reload_r) + 1);
    endfunction

    task automatic expect_done(input string rq, input int lat, input logic chk_ack,
                               input logic ack, input logic chk_dat, input logic [7:0] dat);
        exp_t e;
        e.lat = lat; e.chk_ack = chk_ack; e.ack = ack; e.chk_dat = chk_dat; e.dat = dat;
        sb_q.push_back(e);
        sb_rq.push_back(rq);
    endtask

    // which: 0 start, 1 rstart, 2 stop, 3 rcv, 4 ack, 5 buffer write
    task automatic issue(input int which);
        launch_cyc = cyc + 1;
        case (which)
            0: cmd_start  = 1'b1;
            1: cmd_rstart = 1'b1;
            2: cmd_stop   = 1'b1;
            3: cmd_rcv    = 1'b1;
            4: cmd_ack    = 1'b1;
            default: wr_en = 1'b1;
        endcase
        @(negedge clk);
        cmd_start = 0; cmd_rstart = 0; cmd_stop = 0; cmd_rcv = 0; cmd_ack = 0; wr_en = 0;
    endtask

    task automatic wait_done();
        while (sb_q.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    // monitor: pops one expected item per completion
    initial begin
        exp_t  e;
        string r;
        forever begin
            @(negedge clk);
            if (!rst && irq) begin
                if (sb_q.size() == 0) begin
                    check(1'b0, "R13", "unexpected completion", 1, 0);
                end else begin
                    e = sb_q.pop_front();
                    r = sb_rq.pop_front();
                    check(cyc - launch_cyc == e.lat, r, "completion latency (R1)",
                          cyc - launch_cyc, e.lat);
                    if (e.chk_ack) check(ack_stat == e.ack, r, "ack status", ack_stat, e.ack);
                    if (e.chk_dat) check(rd_data == e.dat, r, "buffer byte", rd_data, e.dat);
                end
                mon_clr = 1'b1;
                @(negedge clk);
                mon_clr = 1'b0;
            end
        end
    end

    task automatic do_tx(input logic [7:0] b, input bit slv_ack, input bit poke);
        logic [7:0] got;
        got = 8'h00;
        expect_done("R4", qlen(36), 1'b1, !slv_ack, 1'b0, 8'h00);
        wr_data = b;
        issue(5);
        check(buf_full == 1'b1, "R5", "buf_full during tx", buf_full, 1);
        fork
            begin
                for (int i = 0; i < 8; i++) begin
                    @(posedge scl_line);
                    got = {got[6:0], sda_line};
                end
                @(negedge scl_line);
                if (slv_ack) slv_low = 1'b1;
                @(negedge scl_line);
                slv_low = 1'b0;
            end
            begin
                if (poke) begin
                    repeat (20) @(negedge clk);
                    wr_data  = 8'h3C;
                    wr_en    = 1'b1;
                    cmd_stop = 1'b1;
                    @(negedge clk);
                    wr_en    = 1'b0;
                    cmd_stop = 1'b0;
                    check(wcol == 1'b1, "R6", "wcol after write during tx", wcol, 1);
                    check(rd_data == b, "R6", "buffer unchanged", rd_data, b);
                    check(cmd_active == 5'b0, "R13", "stop ignored while busy", cmd_active, 0);
                end
            end
        join
        wait_done();
        check(got == b, "R4", "bits seen by slave, MSB first", got, b);
        check(buf_full == 1'b0, "R5", "buf_full after tx", buf_full, 0);
    endtask

    task automatic do_rx(input logic [7:0] b, input logic [7:0] exp_buf);
        expect_done("R7", qlen(32), 1'b0, 1'b0, 1'b1, exp_buf);
        issue(3);
        check(cmd_active == 5'b01000, "R3", "rcv active", cmd_active, 5'b01000);
        slv_low = !b[7];
        for (int i = 6; i >= 0; i--) begin
            @(negedge scl_line);
            slv_low = !b[i];
        end
        @(negedge scl_line);
        slv_low = 1'b0;
        wait_done();
        check(cmd_active == 5'b0, "R3", "rcv self-clears", cmd_active, 0);
    endtask

    task automatic do_ack(input logic a);
        logic seen;
        expect_done("R9", qlen(4), 1'b0, 1'b0, 1'b0, 8'h00);
        ack_data = a;
        issue(4);
        @(posedge scl_line);
        seen = sda_line;
        wait_done();
        check(seen == a, "R9", "sda during ack pulse", seen, a);
        check(cmd_active == 5'b0, "R3", "ack self-clears", cmd_active, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(scl_oe == 0 && sda_oe == 0, "R14", "lines released", {scl_oe, sda_oe}, 0);
        check({irq, wcol, rx_ovf, bus_col, buf_full} == 5'b0, "R14", "flags clear",
              {irq, wcol, rx_ovf, bus_col, buf_full}, 0);
        check(cmd_active == 5'b0, "R14", "no command", cmd_active, 0);

        // START
        expect_done("R2", qlen(4), 1'b0, 1'b0, 1'b0, 8'h00);
        issue(0);
        check(cmd_active == 5'b00001, "R2", "start active", cmd_active, 1);
        wait_done();
        check(cmd_active == 5'b0, "R2", "start self-clears", cmd_active, 0);
        check(start_seen == 1'b1, "R10", "start seen", start_seen, 1);
        check(scl_oe == 1'b1, "R2", "scl held low after start", scl_oe, 1);

        // START on busy bus
        cmd_start = 1'b1;
        @(negedge clk);
        cmd_start = 1'b0;
        check(bus_col == 1'b1, "R11", "bus collision", bus_col, 1);
        check(cmd_active == 5'b0, "R11", "no start launched", cmd_active, 0);
        repeat (20) @(negedge clk);
        check(irq == 1'b0, "R11", "no completion", irq, 0);
        drv_clr = 4'b1000;
        @(negedge clk);
        drv_clr = 4'b0000;
        check(bus_col == 1'b0, "R12", "bus_col cleared by w1c", bus_col, 0);

        // byte transmissions
        do_tx(8'hA5, 1'b1, 1'b1);
        check(stop_seen == 0 && start_seen == 1, "R13", "ignored stop left bus busy",
              {stop_seen, start_seen}, 2'b01);
        do_tx(8'h5A, 1'b0, 1'b0);

        // repeated start
        expect_done("R3", qlen(4), 1'b0, 1'b0, 1'b0, 8'h00);
        issue(1);
        check(cmd_active == 5'b00010, "R3", "rstart active", cmd_active, 5'b00010);
        wait_done();
        check(cmd_active == 5'b0, "R3", "rstart self-clears", cmd_active, 0);

        // receive, then receive again without reading
        do_rx(8'hC3, 8'hC3);
        check(buf_full == 1'b1, "R7", "buf_full after rx", buf_full, 1);
        check(rx_ovf == 1'b0, "R8", "no overflow yet", rx_ovf, 0);
        do_rx(8'h96, 8'hC3);
        check(rx_ovf == 1'b1, "R8", "overflow flagged", rx_ovf, 1);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        check(buf_full == 1'b0, "R7", "read clears buf_full", buf_full, 0);
        do_rx(8'h3E, 8'h3E);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;

        // acknowledge pulses at two divider settings
        reload_r = 8'd1;
        do_ack(1'b1);
        reload_r = 8'd2;
        do_ack(1'b0);

        // sticky flags and selective clear
        check(wcol == 1'b1, "R12", "wcol still set", wcol, 1);
        drv_clr = 4'b0010;
        @(negedge clk);
        drv_clr = 4'b0000;
        check(wcol == 1'b0, "R12", "wcol cleared", wcol, 0);
        check(rx_ovf == 1'b1, "R12", "rx_ovf untouched", rx_ovf, 1);
        drv_clr = 4'b0100;
        @(negedge clk);
        drv_clr = 4'b0000;
        check(rx_ovf == 1'b0, "R12", "rx_ovf cleared", rx_ovf, 0);

        // STOP
        reload_r = 8'd0;
        expect_done("R3", qlen(4), 1'b0, 1'b0, 1'b0, 8'h00);
        issue(2);
        check(cmd_active == 5'b00100, "R3", "stop active", cmd_active, 5'b00100);
        wait_done();
        check(stop_seen == 1 && start_seen == 0, "R10", "stop seen, bus free",
              {stop_seen, start_seen}, 2'b10);
        check(scl_oe == 0 && sda_oe == 0, "R3", "lines released after stop",
              {scl_oe, sda_oe}, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule